// File: doc/BRIEF.md
# Host Sleep Handshake Sequencer

This block is the power-state controller for a storage-controller host that has three supply rails. At power-on it switches the rails on one at a time in a fixed order. It holds the host in reset until the last rail has ramped. Afterwards it handles entry into and exit from a device-sleep state through a two-signal handshake with the host. The host has to report ready before a sleep request is accepted. It then has to withdraw ready before the rails are taken down. A flag on the output tells a wake from sleep apart from a first power-up.

A free-running microsecond tick paces three windows: the glitch filter on the sleep request, the host-ready timeout, and the delay between an undervoltage event and the first rail switching off. Analog ramping is not modelled. Each rail has a ramped flag as an input, and the block only waits on that flag. An undervoltage event overrides everything else. It pulls reset low at once, takes the rails down in a different order, and keeps the block off until the supply is good again.

Top module: `sleep_handshake_seq`

## Requirements
- R1: After reset the filtered sleep request starts high. Once the request has been held low for FILT_TICKS ticks, rails switch on in the order rail2 (railEn[1]), rail3 (railEn[2]), rail1 (railEn[0]). Each rail starts only after the ramped flag of the one before it is high.
- R2: porN goes high only when all three rails are enabled and have ramped, which means after rail1 has ramped.
- R3: A filtered rising sleep request seen while hostReady is high raises slpAck. If hostReady is low, that request is dropped: slpAck stays low and the rails stay on, even if hostReady rises later while the request is still held.
- R4: While slpAck is high, the block waits as long as hostReady stays high. When hostReady falls, porN and slpAck both go low, and the rails switch off in the order rail2, rail3, rail1. Each switches off only after the one before it has ramped down, and the enables never change by more than one bit per cycle.
- R5: A change on sleepReq takes effect only after the new level has been held for FILT_TICKS consecutive ticks. Shorter pulses have no effect.
- R6: On wake from sleep (filtered request low), wakeFlag rises and the rails restart in the order rail2, rail3, rail1. porN is released after rail1 has ramped. wakeFlag clears only once hostReady is high while porN is high.
- R7: If hostReady is still high ACK_TICKS ticks after slpAck rose, the block shuts down anyway: slpAck and porN fall, and the sleep shutdown order follows.
- R8: When underVolt is high, porN and slpAck are low in the next cycle. rail1 is switched off about UV_TICKS ticks later, followed by rail3 and then rail2.
- R9: While underVolt is held after the undervoltage shutdown, sleepReq and hostReady have no effect: the rails, porN and slpAck stay low.
- R10: When underVolt clears, the block repeats the cold start order of R1, with wakeFlag low.
- R11: During reset, railEn, porN, slpAck and wakeFlag are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1us | input | 1 | One-cycle strobe every microsecond |
| sleepReq | input | 1 | Sleep request from the host, high = sleep |
| hostReady | input | 1 | Host-ready handshake input |
| railUp | input | 3 | Ramped flags: bit0 rail1, bit1 rail2, bit2 rail3 |
| underVolt | input | 1 | Input supply below undervoltage threshold |
| railEn | output | 3 | Rail enables: bit0 rail1, bit1 rail2, bit2 rail3 |
| porN | output | 1 | Active-low reset to the host |
| slpAck | output | 1 | Sleep-relay acknowledge |
| wakeFlag | output | 1 | High from a wake start until the host reports ready |

## Verification
Sleep-request pulses are swept over every length from one tick to just under the filter window, then held for exactly the window length. This pins down the threshold where a request starts to count. The request is also raised once with host-ready low and once with it high, which shows that acceptance depends on the handshake and not on the filter alone. Host-ready is withdrawn promptly in one run and kept high in another, which separates the normal handshake from the timeout. Undervoltage is raised while active and then held while the handshake inputs toggle, which shows the distinct shutdown order and that the sleep path has no effect during the event.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  localparam int NUM_RAILS = 3;

  typedef enum logic [3:0] {
    ST_OFF, ST_UP, ST_ACTIVE, ST_ACK, ST_DOWN, ST_SLEEP,
    ST_UVWAIT, ST_UVDOWN, ST_UVHOLD
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       timerClr;
    logic       stepClr;
    logic       stepInc;
    logic       railWr;
    logic       railVal;
    logic [1:0] railIdx;
  } seqStrobe_t;

  // startup and sleep order: rail2, rail3, rail1 (enable bits 1, 2, 0)
  function automatic logic [1:0] upOrder(input logic [1:0] step);
    case (step)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // undervoltage order: rail1, rail3, rail2 (enable bits 0, 2, 1)
  function automatic logic [1:0] uvOrder(input logic [1:0] step);
    case (step)
      2'd0:    return 2'd0;
      2'd1:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int FILT_TICKS = 10000,
  parameter int ACK_TICKS  = 500000,
  parameter int UV_TICKS   = 2000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick1us,
  input  logic                 sleepReq,
  input  seqStrobe_t           strb,
  output logic                 slpFilt,
  output logic                 slpRise,
  output logic                 ackExpired,
  output logic                 uvExpired,
  output logic [1:0]           step,
  output logic [NUM_RAILS-1:0] railEn
);

  localparam int FW   = $clog2(FILT_TICKS + 1);
  localparam int TMAX = ((ACK_TICKS > UV_TICKS) ? ACK_TICKS : UV_TICKS) + 1;
  localparam int TW   = $clog2(TMAX + 1);

  logic [FW-1:0] filtCnt;
  logic [TW-1:0] timer;

  // sleep request glitch filter: new level must persist FILT_TICKS ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slpFilt <= 1'b1;
      filtCnt <= '0;
      slpRise <= 1'b0;
    end else begin
      slpRise <= 1'b0;
      if (sleepReq == slpFilt) begin
        filtCnt <= '0;
      end else if (tick1us) begin
        if (filtCnt == FW'(FILT_TICKS - 1)) begin
          slpFilt <= sleepReq;
          slpRise <= sleepReq;
          filtCnt <= '0;
        end else begin
          filtCnt <= filtCnt + 1'b1;
        end
      end
    end
  end

  // shared tick timer for the host-ready window and the undervoltage delay
  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (strb.timerClr) timer <= '0;
    else if (tick1us && timer != TW'(TMAX)) timer <= timer + 1'b1;
  end

  assign ackExpired = (timer >= TW'(ACK_TICKS));
  assign uvExpired  = (timer >= TW'(UV_TICKS));

  // sequence step and rail enable register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      step   <= '0;
      railEn <= '0;
    end else begin
      if (strb.stepClr) step <= '0;
      else if (strb.stepInc) step <= step + 1'b1;
      for (int i = 0; i < NUM_RAILS; i++)
        if (strb.railWr && strb.railIdx == 2'(i)) railEn[i] <= strb.railVal;
    end
  end

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 underVolt,
  input  logic                 hostReady,
  input  logic [NUM_RAILS-1:0] railUp,
  input  logic                 slpFilt,
  input  logic                 slpRise,
  input  logic                 ackExpired,
  input  logic                 uvExpired,
  input  logic [1:0]           step,
  output seqStrobe_t           strb,
  output logic                 porN,
  output logic                 slpAck,
  output logic                 wakeFlag
);

  seqState_t st, stNxt;
  logic porNxt, ackNxt, wakeNxt;
  logic [1:0] upIdx, uvIdx, upNext, uvNext;

  assign upIdx  = upOrder(step);
  assign uvIdx  = uvOrder(step);
  assign upNext = upOrder(step + 2'd1);
  assign uvNext = uvOrder(step + 2'd1);

  always_comb begin
    stNxt   = st;
    porNxt  = porN;
    ackNxt  = slpAck;
    wakeNxt = wakeFlag;
    strb    = '0;
    if (underVolt && st inside {ST_UP, ST_ACTIVE, ST_ACK, ST_DOWN, ST_SLEEP}) begin
      stNxt         = ST_UVWAIT;
      porNxt        = 1'b0;
      ackNxt        = 1'b0;
      wakeNxt       = 1'b0;
      strb.timerClr = 1'b1;
    end else begin
      case (st)
        ST_OFF: if (!underVolt && !slpFilt) begin
          stNxt        = ST_UP;
          strb.stepClr = 1'b1;
          strb.railWr  = 1'b1;
          strb.railVal = 1'b1;
          strb.railIdx = upOrder(2'd0);
        end
        ST_UP: if (railUp[upIdx]) begin
          if (step == 2'd2) begin
            stNxt  = ST_ACTIVE;
            porNxt = 1'b1;
          end else begin
            strb.stepInc = 1'b1;
            strb.railWr  = 1'b1;
            strb.railVal = 1'b1;
            strb.railIdx = upNext;
          end
        end
        ST_ACTIVE: begin
          if (wakeFlag && hostReady) wakeNxt = 1'b0;
          if (slpRise && hostReady) begin
            stNxt         = ST_ACK;
            ackNxt        = 1'b1;
            strb.timerClr = 1'b1;
          end
        end
        ST_ACK: if (!hostReady || ackExpired) begin
          stNxt        = ST_DOWN;
          porNxt       = 1'b0;
          ackNxt       = 1'b0;
          strb.stepClr = 1'b1;
          strb.railWr  = 1'b1;
          strb.railIdx = upOrder(2'd0);
        end
        ST_DOWN: if (!railUp[upIdx]) begin
          if (step == 2'd2) stNxt = ST_SLEEP;
          else begin
            strb.stepInc = 1'b1;
            strb.railWr  = 1'b1;
            strb.railIdx = upNext;
          end
        end
        ST_SLEEP: if (!slpFilt) begin
          stNxt        = ST_UP;
          wakeNxt      = 1'b1;
          strb.stepClr = 1'b1;
          strb.railWr  = 1'b1;
          strb.railVal = 1'b1;
          strb.railIdx = upOrder(2'd0);
        end
        ST_UVWAIT: if (uvExpired) begin
          stNxt        = ST_UVDOWN;
          strb.stepClr = 1'b1;
          strb.railWr  = 1'b1;
          strb.railIdx = uvOrder(2'd0);
        end
        ST_UVDOWN: if (!railUp[uvIdx]) begin
          if (step == 2'd2) stNxt = ST_UVHOLD;
          else begin
            strb.stepInc = 1'b1;
            strb.railWr  = 1'b1;
            strb.railIdx = uvNext;
          end
        end
        ST_UVHOLD: if (!underVolt) stNxt = ST_OFF;
        default: stNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_OFF;
      porN     <= 1'b0;
      slpAck   <= 1'b0;
      wakeFlag <= 1'b0;
    end else begin
      st       <= stNxt;
      porN     <= porNxt;
      slpAck   <= ackNxt;
      wakeFlag <= wakeNxt;
    end
  end

endmodule

// File: rtl/sleep_handshake_seq.sv
module sleep_handshake_seq
  import sleep_seq_pkg::*;
#(
  parameter int FILT_TICKS = 10000,
  parameter int ACK_TICKS  = 500000,
  parameter int UV_TICKS   = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1us,
  input  logic       sleepReq,
  input  logic       hostReady,
  input  logic [2:0] railUp,
  input  logic       underVolt,
  output logic [2:0] railEn,
  output logic       porN,
  output logic       slpAck,
  output logic       wakeFlag
);

  seqStrobe_t strb;
  logic slpFilt, slpRise, ackExpired, uvExpired;
  logic [1:0] step;

  sleep_seq_dp #(
    .FILT_TICKS(FILT_TICKS), .ACK_TICKS(ACK_TICKS), .UV_TICKS(UV_TICKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .sleepReq(sleepReq),
    .strb(strb), .slpFilt(slpFilt), .slpRise(slpRise),
    .ackExpired(ackExpired), .uvExpired(uvExpired), .step(step),
    .railEn(railEn)
  );

  sleep_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .underVolt(underVolt), .hostReady(hostReady),
    .railUp(railUp), .slpFilt(slpFilt), .slpRise(slpRise),
    .ackExpired(ackExpired), .uvExpired(uvExpired), .step(step),
    .strb(strb), .porN(porN), .slpAck(slpAck), .wakeFlag(wakeFlag)
  );

endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       underVolt,
  input logic [2:0] railEn,
  input logic       porN,
  input logic       slpAck
);

  AST_POR_ALL_RAILS: assert property (@(posedge clk) disable iff (!rstN)
    porN |-> (railEn == 3'b111)); // R2

  AST_ACK_WITH_POR: assert property (@(posedge clk) disable iff (!rstN)
    slpAck |-> porN); // R3

  AST_RAIL3_AFTER_RAIL2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railEn[2]) |-> railEn[1]); // R1

  AST_RAIL1_LAST_UP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railEn[0]) |-> (railEn[1] && railEn[2])); // R1

  AST_ONE_RAIL_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(railEn ^ $past(railEn)) <= 1); // R4

  AST_UV_DROPS_POR: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> !porN); // R8

  AST_UV_DROPS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> !slpAck); // R8

  AST_UV_RAILS_STAY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (underVolt && railEn == 3'b000) |=> (railEn == 3'b000)); // R9

endmodule

bind sleep_handshake_seq sleep_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .underVolt(underVolt), .railEn(railEn),
  .porN(porN), .slpAck(slpAck)
);

// File: tb/sleep_handshake_seq_tb_top.sv
module sleep_handshake_seq_tb_top;

  localparam int FILT = 4;
  localparam int ACKT = 30;
  localparam int UVT  = 5;
  localparam int RAMP = 3;

  logic clk = 1'b0;
  logic rstN, tick1us, sleepReq, hostReady, underVolt;
  logic [2:0] railUp, railEn;
  logic porN, slpAck, wakeFlag;

  int nChk = 0, nFail = 0;
  bit ackSeen = 0;
  int logCnt = 0;
  int logIdx [0:31];
  int logVal [0:31];
  logic [2:0] logUp [0:31];
  logic [2:0] prevEn = 3'b000;
  int rampCnt [0:2];

  always #2 clk = ~clk;

  sleep_handshake_seq #(.FILT_TICKS(FILT), .ACK_TICKS(ACKT), .UV_TICKS(UVT)) dut_i (
    .clk(clk), .rstN(rstN), .tick1us(tick1us), .sleepReq(sleepReq),
    .hostReady(hostReady), .railUp(railUp), .underVolt(underVolt),
    .railEn(railEn), .porN(porN), .slpAck(slpAck), .wakeFlag(wakeFlag)
  );

  // rail model: ramped flag follows the enable after RAMP cycles
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!rstN) begin
        railUp[i] <= 1'b0; rampCnt[i] <= 0;
      end else if (railUp[i] != railEn[i]) begin
        if (rampCnt[i] == RAMP - 1) begin railUp[i] <= railEn[i]; rampCnt[i] <= 0; end
        else rampCnt[i] <= rampCnt[i] + 1;
      end else rampCnt[i] <= 0;
    end
  end

  // event log of rail enable changes, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (slpAck) ackSeen = 1;
      for (int i = 0; i < 3; i++)
        if (railEn[i] != prevEn[i] && logCnt < 32) begin
          logIdx[logCnt] = i; logVal[logCnt] = railEn[i]; logUp[logCnt] = railUp;
          logCnt++;
        end
      prevEn = railEn;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPor(input logic v, input int lim, output int n);
    n = 0;
    while (porN !== v && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic waitAck(input logic v, input int lim, output int n);
    n = 0;
    while (slpAck !== v && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic waitRails(input logic [2:0] v, input int lim);
    int n = 0;
    while (railEn !== v && n < lim) begin @(negedge clk); n++; end
    n = 0;
    while (railUp !== v && n < lim) begin @(negedge clk); n++; end
  endtask

  // check three logged events against an expected order; each must follow the
  // previous rail's ramped flag reaching the same level
  task automatic checkOrder(input string req, input int a, input int b, input int c, input int v);
    int ord [0:2];
    ord[0] = a; ord[1] = b; ord[2] = c;
    chk(logCnt == 3, {req, " event count"}, logCnt, 3);
    for (int k = 0; k < 3; k++) begin
      chk(logIdx[k] == ord[k], {req, " rail order"}, logIdx[k], ord[k]);
      chk(logVal[k] == v, {req, " rail level"}, logVal[k], v);
      if (k > 0)
        chk(int'(logUp[k][ord[k-1]]) == v, {req, " previous rail ramp"},
            int'(logUp[k][ord[k-1]]), v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int n;
    rstN = 0; tick1us = 1; sleepReq = 1; hostReady = 0; underVolt = 0;
    cyc(3);
    // R11 reset state
    chk(railEn == 3'b000, "R11 railEn", railEn, 0);
    chk(porN == 0 && slpAck == 0 && wakeFlag == 0, "R11 flags",
        {porN, slpAck, wakeFlag}, 0);
    rstN = 1;
    cyc(20);
    chk(railEn == 3'b000, "R1 rails off while request high", railEn, 0);

    // R1/R2 cold startup
    logCnt = 0;
    sleepReq = 0;
    waitPor(1, 200, n);
    chk(porN == 1, "R2 porN released", porN, 1);
    chk(railUp == 3'b111, "R2 all rails ramped at release", railUp, 7);
    checkOrder("R1", 1, 2, 0, 1);
    chk(wakeFlag == 0, "R10 cold start wakeFlag", wakeFlag, 0);

    // R3 request ignored while host not ready
    ackSeen = 0;
    sleepReq = 1; cyc(FILT + 5);
    hostReady = 1; cyc(4);
    chk(ackSeen == 0, "R3 ignored without hostReady", ackSeen, 0);
    chk(porN == 1 && railEn == 3'b111, "R3 rails stay on", railEn, 7);
    sleepReq = 0; cyc(FILT + 3);

    // R5 sweep of short pulses
    for (int len = 1; len < FILT; len++) begin
      ackSeen = 0;
      sleepReq = 1; cyc(len);
      sleepReq = 0; cyc(FILT + 3);
      chk(ackSeen == 0, "R5 short pulse ignored", len, 0);
    end

    // R5 exact window then R3 accept
    ackSeen = 0;
    sleepReq = 1;
    cyc(FILT - 1);
    chk(slpAck == 0, "R5 not before window", slpAck, 0);
    waitAck(1, 6, n);
    chk(slpAck == 1, "R3 ack with hostReady", slpAck, 1);

    // R4 waits while host ready, then shuts down
    cyc(10);
    chk(slpAck == 1 && porN == 1, "R4 holds while hostReady", {slpAck, porN}, 3);
    logCnt = 0;
    hostReady = 0;
    cyc(2);
    chk(slpAck == 0, "R4 ack dropped", slpAck, 0);
    chk(porN == 0, "R4 porN low", porN, 0);
    waitRails(3'b000, 100);
    checkOrder("R4", 1, 2, 0, 0);
    cyc(10);
    chk(railEn == 3'b000, "R4 stays asleep", railEn, 0);

    // R6 wake
    logCnt = 0;
    sleepReq = 0;
    waitPor(1, 200, n);
    checkOrder("R6", 1, 2, 0, 1);
    chk(wakeFlag == 1, "R6 wakeFlag at release", wakeFlag, 1);
    chk(railUp == 3'b111, "R6 porN after rail1 ramp", railUp, 7);
    cyc(5);
    chk(wakeFlag == 1, "R6 wakeFlag held", wakeFlag, 1);
    hostReady = 1; cyc(2);
    chk(wakeFlag == 0, "R6 wakeFlag cleared", wakeFlag, 0);

    // R7 timeout with host ready held high
    sleepReq = 1;
    waitAck(1, FILT + 10, n);
    chk(slpAck == 1, "R7 ack raised", slpAck, 1);
    waitAck(0, ACKT + 20, n);
    chk(n >= ACKT && n <= ACKT + 2, "R7 timeout length", n, ACKT + 1);
    chk(porN == 0, "R7 porN low after timeout", porN, 0);
    waitRails(3'b000, 100);
    chk(railEn == 3'b000, "R7 rails down", railEn, 0);
    sleepReq = 0;
    waitPor(1, 200, n);
    cyc(3);
    chk(wakeFlag == 0 && porN == 1, "R6 wake with hostReady high", wakeFlag, 0);

    // R8 undervoltage shutdown
    logCnt = 0;
    underVolt = 1;
    cyc(1);
    chk(porN == 0, "R8 porN immediate", porN, 0);
    chk(railEn == 3'b111, "R8 rails held during delay", railEn, 7);
    n = 1;
    while (railEn[0] && n < 100) begin cyc(1); n++; end
    chk(n >= UVT + 1 && n <= UVT + 3, "R8 delay length", n, UVT + 2);
    waitRails(3'b000, 100);
    checkOrder("R8", 0, 2, 1, 0);

    // R9 handshake inputs ignored under undervoltage
    ackSeen = 0;
    hostReady = 0; sleepReq = 1; cyc(FILT + 2);
    hostReady = 1; cyc(3);
    sleepReq = 0; cyc(FILT + 3);
    hostReady = 0; cyc(3);
    chk(railEn == 3'b000, "R9 rails stay off", railEn, 0);
    chk(porN == 0 && ackSeen == 0, "R9 no porN or ack", {porN, ackSeen}, 0);

    // R10 restart after undervoltage clears
    logCnt = 0;
    underVolt = 0;
    waitPor(1, 200, n);
    checkOrder("R10", 1, 2, 0, 1);
    chk(wakeFlag == 0, "R10 wakeFlag low", wakeFlag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule